// File: doc/BRIEF.md
# Slow RC Oscillator Calibration Sequencer

This block trims a nominally 10 kHz on-chip RC oscillator in two passes. After a start pulse it selects slow-oscillator measurement and loads the neutral tune and divisor values. It then waits for the period counter to settle and takes one period reading. The reading is the count of 12 MHz cycles in 16 oscillator cycles, so the ideal value is 19200. From it the block derives a signed coarse trim step, clamps it to the 4-bit trim range and drives it to the oscillator.

In the second pass it takes eight more readings, with a settle wait before each one. It averages them with rounding and divides a fixed constant by the average. The quotient is a 16-bit fixed-point divisor (integer part in bits 15:11, fraction in bits 10:0) that a downstream fractional divider uses to produce 1024 Hz. A single shared multi-cycle restoring divider serves both passes.

Period readings arrive on a valid/ready stream. The block raises ready only once a settle wait has elapsed, and it holds ready until a reading is taken. The source may hold valid low for any number of cycles. A value is consumed only on a clock edge where valid and ready are both high. Settle waits are counted in ticks of an external microsecond timebase.

Top module: `slowrc_cal_seq`

## Requirements
- R1: A start pulse while idle makes busy_o rise on the next edge. On that edge mode_o is driven 0, tune_o is loaded with 0, and divisor_o is loaded with 0x5000 (divide by 10.0: bits 15:11 are the integer part and bits 10:0 the fraction).
- R2: Before every period reading, period_ready_o stays low until at least SETTLE_US microsecond ticks have arrived since that wait began. The default is 4250; the bench uses 12.
- R3: A reading is taken only on an edge where period_valid_i and period_ready_o are both high. Once raised, ready stays high until a reading is taken. Each calibration run takes exactly 9 readings: 1 coarse and 8 averaged.
- R4: The coarse step is (19600 − P) / 800 with signed division that truncates toward zero, where P is the first reading. It is clamped to −8..+7 and driven on tune_o as 4-bit two's complement before the averaged readings begin.
- R5: The average of the 8 later readings is floor((sum + 4) / 8).
- R6: The final divisor is floor(384000000 / average) truncated to its low 16 bits.
- R7: If the average is zero, no division is made and divisor_o keeps 0x5000.
- R8: done_o is high for exactly one cycle, on the edge that writes the final divisor. busy_o falls on that same edge.
- R9: A start pulse while busy has no effect: the run is not restarted, and tune_o and divisor_o are not reloaded.
- R10: After reset: busy_o, done_o, period_ready_o and mode_o are 0, tune_o is 0, and divisor_o is 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a calibration run |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| period_i | input | 16 | Period reading (12 MHz cycles per 16 RC cycles) |
| period_valid_i | input | 1 | period_i holds a usable reading |
| period_ready_o | output | 1 | Block accepts a reading on this edge |
| tune_o | output | 4 | Signed coarse trim to the oscillator |
| divisor_o | output | 16 | Fixed-point divisor, 5.11 format |
| mode_o | output | 1 | Measurement select, 0 = slow RC |
| busy_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | One-cycle pulse when the divisor is written |

## Verification
On every cycle, the bound checker enforces the stream rules, the one-cycle done pulse and its coincidence with the fall of busy, the reload of tune and divisor at start, and that the divisor stays frozen and the run keeps going when a start arrives while busy. Only the bench scenarios can show the arithmetic results: truncation toward zero at negative differences, clamping at both ends of the trim range, rounding of the average, 16-bit truncation of large quotients and the zero-average bypass. The same holds for the settle tick count before each reading and the reading count per run.

// File: rtl/slowrc_cal_pkg.sv
package slowrc_cal_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_WAIT,
    CAL_READ,
    CAL_COARSE,
    CAL_AVG_PREP,
    CAL_AVG
  } cal_state_e;

endpackage

// File: rtl/slowrc_settle_timer.sv
module slowrc_settle_timer #(
  parameter int SETTLE_US = 4250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CNT_W = (SETTLE_US > 1) ? $clog2(SETTLE_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_US - 1);

  logic [CNT_W-1:0] cnt_q;

  // counter restarts whenever the sequencer is outside a wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/slowrc_period_accum.sv
module slowrc_period_accum #(
  parameter int PERIOD_W    = 16,
  parameter int NUM_SAMPLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [PERIOD_W-1:0] data_i,
  output logic                last_o,
  output logic [PERIOD_W-1:0] avg_o
);
  localparam int LOG2_N = (NUM_SAMPLES > 1) ? $clog2(NUM_SAMPLES) : 1;
  localparam int SUM_W  = PERIOD_W + LOG2_N;
  localparam logic [LOG2_N-1:0] CNT_LAST = LOG2_N'(NUM_SAMPLES - 1);
  localparam logic [SUM_W:0]    HALF     = (SUM_W+1)'(NUM_SAMPLES / 2);

  logic [SUM_W-1:0]  sum_q;
  logic [LOG2_N-1:0] cnt_q;
  logic [SUM_W:0]    rounded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (add_i) begin
      sum_q <= sum_q + SUM_W'(data_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o  = add_i && (cnt_q == CNT_LAST);
  assign rounded = {1'b0, sum_q} + HALF;
  assign avg_o   = rounded[LOG2_N +: PERIOD_W];
endmodule

// File: rtl/slowrc_coarse_calc.sv
module slowrc_coarse_calc #(
  parameter int PERIOD_W       = 16,
  parameter int TUNE_W         = 4,
  parameter int CALC_W         = 32,
  parameter int TARGET_ROUNDED = 19600
) (
  input  logic [PERIOD_W-1:0] period_i,
  output logic                neg_o,
  output logic [CALC_W-1:0]   mag_o,
  input  logic                neg_i,
  input  logic [CALC_W-1:0]   quot_i,
  output logic [TUNE_W-1:0]   tune_o
);
  localparam logic [CALC_W-1:0] POS_LIM = CALC_W'(2 ** (TUNE_W - 1) - 1);
  localparam logic [CALC_W-1:0] NEG_LIM = CALC_W'(2 ** (TUNE_W - 1));

  logic signed [CALC_W:0] diff_s;
  logic        [CALC_W:0] diff_neg;

  // signed difference from the rounded target; magnitude goes to the divider
  always_comb begin
    diff_s   = $signed((CALC_W+1)'(TARGET_ROUNDED)) -
               $signed({{(CALC_W+1-PERIOD_W){1'b0}}, period_i});
    diff_neg = -diff_s;
    neg_o    = diff_s[CALC_W];
    mag_o    = neg_o ? diff_neg[CALC_W-1:0] : diff_s[CALC_W-1:0];
  end

  // sign restored after a magnitude division truncates toward zero; clamp to range
  always_comb begin
    if (!neg_i) begin
      tune_o = (quot_i > POS_LIM) ? POS_LIM[TUNE_W-1:0] : quot_i[TUNE_W-1:0];
    end else if (quot_i > NEG_LIM) begin
      tune_o = NEG_LIM[TUNE_W-1:0];
    end else begin
      tune_o = (~quot_i[TUNE_W-1:0]) + 1'b1;
    end
  end
endmodule

// File: rtl/slowrc_seq_divider.sv
module slowrc_seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shifted;
  logic             fits;

  assign shifted = {rem_q[W-1:0], quo_q[W-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  // restoring division: one quotient bit per cycle, most significant first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CNT_W'(W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? (shifted - {1'b0, dvs_q}) : shifted;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_o <= 1'b1;
      end
    end
  end

  assign quot_o = quo_q;
endmodule

// File: rtl/slowrc_cal_seq.sv
module slowrc_cal_seq
  import slowrc_cal_pkg::*;
#(
  parameter int PERIOD_W       = 16,
  parameter int TUNE_W         = 4,
  parameter int DIVR_W         = 16,
  parameter int SETTLE_US      = 4250,
  parameter int NUM_SAMPLES    = 8,
  parameter int TARGET_ROUNDED = 19600,
  parameter int STEP_SIZE      = 800,
  parameter int CAL_NUMERATOR  = 384000000,
  parameter int CALC_W         = 32,
  parameter logic [DIVR_W-1:0] DIV_RESET  = 16'h5000,
  parameter logic [TUNE_W-1:0] TUNE_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                us_tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                period_valid_i,
  output logic                period_ready_o,
  output logic [TUNE_W-1:0]   tune_o,
  output logic [DIVR_W-1:0]   divisor_o,
  output logic                mode_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam logic [CALC_W-1:0] STEP_C = CALC_W'(STEP_SIZE);
  localparam logic [CALC_W-1:0] NUM_C  = CALC_W'(CAL_NUMERATOR);

  cal_state_e state_q;
  logic       coarse_q;
  logic       neg_q;

  logic                taken;
  logic                settle_done;
  logic                acc_clr, acc_last;
  logic [PERIOD_W-1:0] avg;
  logic                calc_neg;
  logic [CALC_W-1:0]   calc_mag;
  logic [TUNE_W-1:0]   tune_next;
  logic                div_start, div_done;
  logic [CALC_W-1:0]   div_a, div_b, div_q;

  assign taken     = period_valid_i && period_ready_o;
  assign acc_clr   = (state_q == CAL_IDLE);
  assign div_start = (taken && coarse_q) ||
                     (state_q == CAL_AVG_PREP && avg != '0);
  assign div_a     = coarse_q ? calc_mag : NUM_C;
  assign div_b     = coarse_q ? STEP_C : CALC_W'(avg);

  slowrc_settle_timer #(.SETTLE_US(SETTLE_US)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (state_q == CAL_WAIT),
    .tick_i   (us_tick_i),
    .expire_o (settle_done)
  );

  slowrc_period_accum #(.PERIOD_W(PERIOD_W), .NUM_SAMPLES(NUM_SAMPLES)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (acc_clr),
    .add_i  (taken && !coarse_q),
    .data_i (period_i),
    .last_o (acc_last),
    .avg_o  (avg)
  );

  slowrc_coarse_calc #(
    .PERIOD_W(PERIOD_W), .TUNE_W(TUNE_W), .CALC_W(CALC_W),
    .TARGET_ROUNDED(TARGET_ROUNDED)
  ) u_coarse (
    .period_i (period_i),
    .neg_o    (calc_neg),
    .mag_o    (calc_mag),
    .neg_i    (neg_q),
    .quot_i   (div_q),
    .tune_o   (tune_next)
  );

  slowrc_seq_divider #(.W(CALC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .done_o     (div_done),
    .quot_o     (div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= CAL_IDLE;
      coarse_q       <= 1'b0;
      neg_q          <= 1'b0;
      period_ready_o <= 1'b0;
      tune_o         <= TUNE_RESET;
      divisor_o      <= DIV_RESET;
      mode_o         <= 1'b0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        CAL_IDLE: begin
          if (start_i) begin
            tune_o    <= TUNE_RESET;
            divisor_o <= DIV_RESET;
            mode_o    <= 1'b0;
            busy_o    <= 1'b1;
            coarse_q  <= 1'b1;
            state_q   <= CAL_WAIT;
          end
        end
        CAL_WAIT: begin
          if (settle_done) begin
            period_ready_o <= 1'b1;
            state_q        <= CAL_READ;
          end
        end
        CAL_READ: begin
          if (taken) begin
            period_ready_o <= 1'b0;
            if (coarse_q) begin
              neg_q   <= calc_neg;
              state_q <= CAL_COARSE;
            end else if (acc_last) begin
              state_q <= CAL_AVG_PREP;
            end else begin
              state_q <= CAL_WAIT;
            end
          end
        end
        CAL_COARSE: begin
          if (div_done) begin
            tune_o   <= tune_next;
            coarse_q <= 1'b0;
            state_q  <= CAL_WAIT;
          end
        end
        CAL_AVG_PREP: begin
          if (avg == '0) begin
            // zero average: divisor keeps its reset value
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= CAL_IDLE;
          end else begin
            state_q <= CAL_AVG;
          end
        end
        CAL_AVG: begin
          if (div_done) begin
            divisor_o <= div_q[DIVR_W-1:0];
            done_o    <= 1'b1;
            busy_o    <= 1'b0;
            state_q   <= CAL_IDLE;
          end
        end
        default: state_q <= CAL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slowrc_cal_seq_checker.sv
module slowrc_cal_seq_checker #(
  parameter int TUNE_W = 4,
  parameter int DIVR_W = 16,
  parameter logic [DIVR_W-1:0] DIV_RESET  = 16'h5000,
  parameter logic [TUNE_W-1:0] TUNE_RESET = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              period_valid_i,
  input logic              period_ready_o,
  input logic [TUNE_W-1:0] tune_o,
  input logic [DIVR_W-1:0] divisor_o,
  input logic              mode_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_start_accepted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  assert_start_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (divisor_o == DIV_RESET && tune_o == TUNE_RESET && !mode_o));

  assert_ready_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_ready_o && !period_valid_i) |=> period_ready_o);

  assert_ready_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_ready_o |-> busy_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  assert_divisor_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(divisor_o));

  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind slowrc_cal_seq slowrc_cal_seq_checker #(
  .TUNE_W(TUNE_W), .DIVR_W(DIVR_W), .DIV_RESET(DIV_RESET), .TUNE_RESET(TUNE_RESET)
) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .period_valid_i (period_valid_i),
  .period_ready_o (period_ready_o),
  .tune_o         (tune_o),
  .divisor_o      (divisor_o),
  .mode_o         (mode_o),
  .busy_o         (busy_o),
  .done_o         (done_o)
);

// File: tb/slowrc_cal_seq_bench.sv
`timescale 1ns/1ps
module slowrc_cal_seq_bench;
  localparam int SETTLE = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        us_tick_i = 1'b0;
  logic [15:0] period_i = '0;
  logic        period_valid_i = 1'b0;
  logic        period_ready_o;
  logic [3:0]  tune_o;
  logic [15:0] divisor_o;
  logic        mode_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  slowrc_cal_seq #(.SETTLE_US(SETTLE)) u_slowrc_cal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .us_tick_i(us_tick_i),
    .period_i(period_i), .period_valid_i(period_valid_i),
    .period_ready_o(period_ready_o), .tune_o(tune_o), .divisor_o(divisor_o),
    .mode_o(mode_o), .busy_o(busy_o), .done_o(done_o)
  );

  int unsigned pv[9];
  int          hs_cnt = 0;
  int          base = 0;
  bit          gaps = 1'b0;
  int          n_chk = 0, n_fail = 0;
  int          n_chk_t = 0, n_fail_t = 0;
  int          tick_ph = 0;
  int          ticks_seen = 0;

  function automatic int exp_tune(input int unsigned p);
    int s;
    s = (19600 - int'(p)) / 800;
    if (s > 7) s = 7;
    if (s < -8) s = -8;
    return s & 15;
  endfunction

  function automatic int exp_div();
    int unsigned sum, avg;
    sum = 0;
    for (int i = 1; i < 9; i++) sum += pv[i];
    avg = (sum + 4) / 8;
    if (avg == 0) return 'h5000;
    return (384000000 / avg) & 'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // readings taken on edges with valid and ready both high
  always @(posedge clk)
    if (rst_n && period_valid_i && period_ready_o) hs_cnt++;

  // source side, microsecond tick and settle-tick measurement
  always @(negedge clk) begin
    int idx;
    idx = hs_cnt - base;
    if (idx > 8) idx = 8;
    if (idx < 0) idx = 0;
    period_i = 16'(pv[idx]);
    period_valid_i = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
    tick_ph = (tick_ph == 2) ? 0 : tick_ph + 1;
    us_tick_i = (tick_ph == 0);
    if (!busy_o) ticks_seen = 0;
    else if (period_ready_o) begin
      if (ticks_seen != 0) begin
        // R2: ready only after the full settle count (a division may add a few)
        n_chk_t++;
        if (ticks_seen < SETTLE || ticks_seen > SETTLE + 14) begin
          n_fail_t++;
          $display("FAIL R2: actual %0d expected %0d ticks", ticks_seen, SETTLE);
        end
      end
      ticks_seen = 0;
    end else if (us_tick_i) ticks_seen++;
  end

  task automatic run_cal(input bit stray);
    int cyc;
    int t_hold;
    int et, ed;
    et = exp_tune(pv[0]);
    ed = exp_div();
    @(negedge clk);
    start_i = 1'b1;
    base = hs_cnt;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy", busy_o, 1);
    chk(tune_o == 4'd0 && divisor_o == 16'h5000 && mode_o == 1'b0, "R1 reload",
        divisor_o, 'h5000);
    cyc = 0;
    if (stray) begin
      while (hs_cnt - base < 3 && cyc < 5000) begin @(negedge clk); cyc++; end
      t_hold = tune_o;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && int'(tune_o) == t_hold, "R9 tune kept", tune_o, t_hold);
      chk(divisor_o == 16'h5000 && hs_cnt - base >= 3, "R9 no restart", hs_cnt - base, 3);
    end
    while (!done_o && cyc < 5000) begin @(negedge clk); cyc++; end
    if (cyc >= 5000) begin
      chk(1'b0, "watchdog", cyc, 5000);
      return;
    end
    chk(int'(tune_o) == et, "R4 tune", tune_o, et);
    chk(int'(divisor_o) == ed, "R5 R6 R7 divisor", divisor_o, ed);
    chk(hs_cnt - base == 9, "R3 readings", hs_cnt - base, 9);
    chk(busy_o == 1'b0, "R8 busy falls", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 single pulse", done_o, 0);
  endtask

  task automatic fill(input int unsigned p0, input int unsigned ps);
    pv[0] = p0;
    for (int i = 1; i < 9; i++) pv[i] = ps;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1A));
    for (int i = 0; i < 9; i++) pv[i] = 19200;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && period_ready_o == 0 && mode_o == 0,
        "R10 flags", busy_o, 0);
    chk(tune_o == 0 && divisor_o == 16'h5000, "R10 values", divisor_o, 'h5000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill(19200, 19200); run_cal(1'b0);            // R4 zero step, R6 nominal
    fill(0, 19200);     run_cal(1'b0);            // R4 clamp at +7
    fill(65535, 1000);  run_cal(1'b0);            // R4 clamp at -8, R6 truncation
    fill(20001, 19000); run_cal(1'b0);            // R4 truncates toward zero
    fill(20400, 18000); run_cal(1'b0);            // R4 exactly -1
    fill(18800, 22000); run_cal(1'b0);            // R4 exactly +1
    fill(19200, 0);     pv[4] = 3; run_cal(1'b0); // R7 average rounds to zero
    fill(19200, 0);     pv[2] = 4; run_cal(1'b0); // R5 rounds up to 1
    fill(19200, 1000);  pv[8] = 1004; run_cal(1'b1); // R5 rounding, R9 stray start
    gaps = 1'b1;
    for (int r = 0; r < 20; r++) begin
      pv[0] = (r % 4 == 0) ? $urandom_range(0, 65535) : $urandom_range(11200, 27200);
      for (int i = 1; i < 9; i++)
        pv[i] = (r % 5 == 0) ? $urandom_range(1, 65535) : $urandom_range(17000, 21500);
      run_cal(r % 7 == 3);
    end
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + n_chk_t, n_fail + n_fail_t);
    $finish;
  end
endmodule